// File: doc/BRIEF.md
# Cascaded Decade Timebase Divider

This block turns a slow periodic tick into a family of binary-weighted timing taps. It holds six decimal digit counters that all run from one system clock. The first digit advances on every accepted tick. Each later digit advances once for every full cycle of the digit before it. With the default 10 kHz tick, the low digit's bits carry 0.1, 0.2, 0.4 and 0.8 ms periods. The second digit gives 1 to 8 ms taps. The fourth digit gives 100 to 800 ms taps. The two low bits of the sixth digit give 10 s and 20 s taps.

A tick is accepted only while four run-permission lines are all high. Either of two active-low clear lines resets every digit on the next clock edge, and a clear wins over counting. The tick arrives as a one-cycle enable pulse inside a faster system clock, not as a clock of its own.

Top module: `decade_timebase`

## Requirements
- R1: While either clear input is low at a rising clock edge, every digit reads 0 after that edge, whatever the tick and run inputs do.
- R2: When tickEn is low, or any bit of runOk[3:0] is low, and no clear is active, every digit keeps its value across the edge.
- R3: Digit 0 goes up by one on each accepted tick (tickEn high and runOk equal to 4'b1111), and goes from RADIX-1 back to 0.
- R4: Digit 1 goes up by one exactly on the accepted ticks at which digit 0 holds RADIX-1, so it advances once per RADIX accepted ticks.
- R5: Digits 2 to 5 each go up by one only on an accepted tick at which digit 0 and the digit just below are both at RADIX-1 and that lower digit is itself being advanced on the same tick.
- R6: No digit ever holds a value above RADIX-1.
- R7: tapFine equals digit 0, tapMs equals digit 1 and tapDeci equals digit 3, each with bit 0 as the lowest weight. tapSec[1:0] equals bits 1:0 of digit 5.
- R8: With all six digits at RADIX-1, one accepted tick returns every digit to 0.
- R9: clrA_n alone and clrB_n alone each clear all digits while the other clear input stays high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| tickEn | input | 1 | One-cycle timebase tick |
| runOk | input | 4 | Run permissions; all must be high for counting |
| clrA_n | input | 1 | Active-low clear, first source |
| clrB_n | input | 1 | Active-low clear, second source |
| tapFine | output | DIGIT_W | Digit 0 bits (0.1 to 0.8 ms taps) |
| tapMs | output | DIGIT_W | Digit 1 bits (1 to 8 ms taps) |
| tapDeci | output | DIGIT_W | Digit 3 bits (100 to 800 ms taps) |
| tapSec | output | 2 | Digit 5 bits 1:0 (10 s and 20 s taps) |

## Verification
The bench keeps six digits and a tick every cycle, but builds the block with RADIX set to 4. The whole chain then wraps after 4096 accepted ticks instead of a million. That puts every stage rollover, including the wrap from all digits at their highest value back to zero, within a short run that compares all taps after every tick. With the smaller radix, each digit still runs through the full range of its two-bit-or-wider value. The same enable chain and terminal-count logic are exercised at every stage.

// File: rtl/decade_timebase_pkg.sv
package decade_timebase_pkg;

  // Strobes issued by the control path once per system clock.
  typedef struct packed {
    logic clear;  // synchronous clear of every digit
    logic step;   // accepted tick, drives the lowest digit
  } tbStrobe_t;

endpackage

// File: rtl/decade_timebase_digit.sv
module decade_timebase_digit #(
  parameter int RADIX   = 10,
  parameter int DIGIT_W = 4
) (
  input  logic               clk,
  input  logic               clear,
  input  logic               en,
  output logic [DIGIT_W-1:0] count,
  output logic               atLast,
  output logic               tc
);

  localparam logic [DIGIT_W-1:0] LAST = DIGIT_W'(RADIX - 1);

  logic [DIGIT_W-1:0] countNext;

  always_comb begin
    countNext = count;
    if (clear) begin
      countNext = '0;
    end else if (en) begin
      countNext = (count == LAST) ? '0 : count + 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    count <= countNext;
  end

  assign atLast = (count == LAST);
  // Terminal count lasts only for the enabled cycle at the last value.
  assign tc     = atLast && en;

  p_digit_range_r6 : assert property (@(posedge clk) disable iff (clear)
    count <= LAST);

  p_wrap_to_zero_r3 : assert property (@(posedge clk) disable iff (clear)
    (en && atLast) |=> (count == '0));

  p_clear_zero_r1 : assert property (@(posedge clk)
    clear |=> (count == '0));

endmodule

// File: rtl/decade_timebase_ctrl.sv
module decade_timebase_ctrl
  import decade_timebase_pkg::*;
#(
  parameter int NUM_RUN = 4
) (
  input  logic               tickEn,
  input  logic [NUM_RUN-1:0] runOk,
  input  logic               clrA_n,
  input  logic               clrB_n,
  output tbStrobe_t          strobes
);

  logic clearAny;
  logic runAll;

  assign clearAny = !(clrA_n && clrB_n);
  assign runAll   = &runOk;

  always_comb begin
    strobes.clear = clearAny;
    // Clear has priority, so a tick during clear is dropped.
    strobes.step  = tickEn && runAll && !clearAny;
  end

endmodule

// File: rtl/decade_timebase_chain.sv
module decade_timebase_chain
  import decade_timebase_pkg::*;
#(
  parameter int NUM_DEC = 6,
  parameter int RADIX   = 10,
  parameter int DIGIT_W = 4
) (
  input  logic                       clk,
  input  tbStrobe_t                  strobes,
  output logic [NUM_DEC*DIGIT_W-1:0] digitsFlat
);

  logic [NUM_DEC-1:0] stageEn;
  logic [NUM_DEC-1:0] stageTc;
  logic [NUM_DEC-1:0] stageLast;

  for (genvar k = 0; k < NUM_DEC; k++) begin : g_stage
    if (k == 0) begin : g_first
      assign stageEn[k] = strobes.step;
    end else if (k == 1) begin : g_second
      assign stageEn[k] = stageTc[0];
    end else begin : g_upper
      // Upper digits need both the lowest and the preceding terminal count.
      assign stageEn[k] = stageTc[0] && stageTc[k-1];
    end

    decade_timebase_digit #(
      .RADIX  (RADIX),
      .DIGIT_W(DIGIT_W)
    ) u_digit (
      .clk   (clk),
      .clear (strobes.clear),
      .en    (stageEn[k]),
      .count (digitsFlat[k*DIGIT_W +: DIGIT_W]),
      .atLast(stageLast[k]),
      .tc    (stageTc[k])
    );

    if (k >= 1) begin : g_gate_chk
      p_stage_gate_r5 : assert property (@(posedge clk) disable iff (strobes.clear)
        !(strobes.step && stageLast[0] && stageLast[k-1])
          |=> $stable(digitsFlat[k*DIGIT_W +: DIGIT_W]));
    end
  end

  p_hold_no_step_r2 : assert property (@(posedge clk) disable iff (strobes.clear)
    !strobes.step |=> $stable(digitsFlat));

endmodule

// File: rtl/decade_timebase.sv
module decade_timebase
  import decade_timebase_pkg::*;
#(
  parameter int NUM_DEC = 6,
  parameter int RADIX   = 10,
  parameter int DIGIT_W = 4
) (
  input  logic               clk,
  input  logic               tickEn,
  input  logic [3:0]         runOk,
  input  logic               clrA_n,
  input  logic               clrB_n,
  output logic [DIGIT_W-1:0] tapFine,
  output logic [DIGIT_W-1:0] tapMs,
  output logic [DIGIT_W-1:0] tapDeci,
  output logic [1:0]         tapSec
);

  localparam int FINE_IDX = 0;
  localparam int MS_IDX   = 1;
  localparam int DECI_IDX = 3;
  localparam int SEC_IDX  = NUM_DEC - 1;

  tbStrobe_t                  strobes;
  logic [NUM_DEC*DIGIT_W-1:0] digitsFlat;

  decade_timebase_ctrl #(
    .NUM_RUN(4)
  ) u_ctrl (
    .tickEn (tickEn),
    .runOk  (runOk),
    .clrA_n (clrA_n),
    .clrB_n (clrB_n),
    .strobes(strobes)
  );

  decade_timebase_chain #(
    .NUM_DEC(NUM_DEC),
    .RADIX  (RADIX),
    .DIGIT_W(DIGIT_W)
  ) u_chain (
    .clk       (clk),
    .strobes   (strobes),
    .digitsFlat(digitsFlat)
  );

  assign tapFine = digitsFlat[FINE_IDX*DIGIT_W +: DIGIT_W];
  assign tapMs   = digitsFlat[MS_IDX*DIGIT_W   +: DIGIT_W];
  assign tapDeci = digitsFlat[DECI_IDX*DIGIT_W +: DIGIT_W];
  assign tapSec  = digitsFlat[SEC_IDX*DIGIT_W  +: 2];

  p_pin_clear_r9 : assert property (@(posedge clk)
    (!clrA_n || !clrB_n) |=> (tapFine == '0 && tapMs == '0 && tapDeci == '0 && tapSec == '0));

endmodule

// File: tb/decade_timebase_tb.sv
module decade_timebase_tb;

  localparam int RADIX   = 4;
  localparam int NUM_DEC = 6;
  localparam int DIGIT_W = 4;
  localparam int FULL    = RADIX ** NUM_DEC;

  logic               clk = 1'b0;
  logic               tickEn = 1'b0;
  logic [3:0]         runOk = 4'h0;
  logic               clrA_n = 1'b0;
  logic               clrB_n = 1'b0;
  logic [DIGIT_W-1:0] tapFine;
  logic [DIGIT_W-1:0] tapMs;
  logic [DIGIT_W-1:0] tapDeci;
  logic [1:0]         tapSec;

  int nChecks = 0;
  int nFails  = 0;
  int model   = 0;
  bit done    = 1'b0;

  always #5 clk = ~clk;

  decade_timebase #(
    .NUM_DEC(NUM_DEC),
    .RADIX  (RADIX),
    .DIGIT_W(DIGIT_W)
  ) u_dut (
    .clk    (clk),
    .tickEn (tickEn),
    .runOk  (runOk),
    .clrA_n (clrA_n),
    .clrB_n (clrB_n),
    .tapFine(tapFine),
    .tapMs  (tapMs),
    .tapDeci(tapDeci),
    .tapSec (tapSec)
  );

  // Fields: runOk[11:8], tick[7], clrA_n[6], clrB_n[5], expected total count[4:0]
  localparam logic [11:0] VEC [13] = '{
    {4'hF, 1'b1, 1'b1, 1'b1, 5'd1},   // R3 step
    {4'hF, 1'b1, 1'b1, 1'b1, 5'd2},   // R3 step
    {4'hF, 1'b0, 1'b1, 1'b1, 5'd2},   // R2 no tick
    {4'hE, 1'b1, 1'b1, 1'b1, 5'd2},   // R2 one run bit low
    {4'h7, 1'b1, 1'b1, 1'b1, 5'd2},   // R2 top run bit low
    {4'hF, 1'b1, 1'b1, 1'b1, 5'd3},   // R3 reach last
    {4'hF, 1'b1, 1'b1, 1'b1, 5'd4},   // R4 digit 1 advances
    {4'hB, 1'b1, 1'b1, 1'b1, 5'd4},   // R2 hold
    {4'hF, 1'b1, 1'b0, 1'b1, 5'd0},   // R9 clear A alone
    {4'hF, 1'b1, 1'b1, 1'b1, 5'd1},   // R3
    {4'hF, 1'b1, 1'b1, 1'b0, 5'd0},   // R9 clear B alone
    {4'hD, 1'b1, 1'b1, 1'b1, 5'd0},   // R2 hold at zero
    {4'hF, 1'b1, 1'b1, 1'b1, 5'd1}    // R3
  };

  task automatic check(input int act, input int exp, input string tag);
    nChecks++;
    if (act != exp) begin
      nFails++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  function automatic int digitOf(input int total, input int idx);
    return (total / (RADIX ** idx)) % RADIX;
  endfunction

  task automatic checkTaps(input int total, input string ctx);
    check(int'(tapFine), digitOf(total, 0),     {ctx, " R3 digit0"});
    check(int'(tapMs),   digitOf(total, 1),     {ctx, " R4 digit1"});
    check(int'(tapDeci), digitOf(total, 3),     {ctx, " R5 digit3"});
    check(int'(tapSec),  digitOf(total, 5) % 4, {ctx, " R7 digit5"});
  endtask

  // Drive at the falling edge, sample two units after the next rising edge.
  task automatic drive(input logic [3:0] ok, input logic tk, input logic a, input logic b);
    @(negedge clk);
    runOk  = ok;
    tickEn = tk;
    clrA_n = a;
    clrB_n = b;
    @(posedge clk);
    #2;
    if (!a || !b) model = 0;
    else if (tk && ok == 4'hF) model = (model + 1) % FULL;
  endtask

  initial begin
    #(200_000 * 10);
    if (!done) begin
      nChecks++;
      nFails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
      $finish;
    end
  end

  initial begin
    // R1 reset state with tick and run high during clear
    drive(4'hF, 1'b1, 1'b0, 1'b0);
    drive(4'hF, 1'b1, 1'b0, 1'b0);
    checkTaps(0, "reset R1");

    for (int i = 0; i < 13; i++) begin
      drive(VEC[i][11:8], VEC[i][7], VEC[i][6], VEC[i][5]);
      checkTaps(int'(VEC[i][4:0]), $sformatf("vec%0d", i));
      model = int'(VEC[i][4:0]);
    end

    // Full run through every stage rollover, checked each tick (R4, R5)
    drive(4'hF, 1'b0, 1'b0, 1'b1);
    for (int i = 1; i < FULL; i++) begin
      drive(4'hF, 1'b1, 1'b1, 1'b1);
      checkTaps(i, "run");
    end

    // R2 hold with every digit at its last value
    drive(4'hE, 1'b1, 1'b1, 1'b1);
    checkTaps(FULL - 1, "hold-at-top R2");
    drive(4'hF, 1'b0, 1'b1, 1'b1);
    checkTaps(FULL - 1, "hold-no-tick R2");

    // R8 full wrap back to zero
    drive(4'hF, 1'b1, 1'b1, 1'b1);
    checkTaps(0, "wrap R8");

    // Mid-count clear beats a simultaneous tick (R1)
    for (int i = 0; i < 1234; i++) drive(4'hF, 1'b1, 1'b1, 1'b1);
    checkTaps(1234, "mid-run");
    drive(4'hF, 1'b1, 1'b0, 1'b1);
    checkTaps(0, "mid clear A R1");
    for (int i = 0; i < 777; i++) drive(4'hF, 1'b1, 1'b1, 1'b1);
    checkTaps(777, "mid-run2");
    drive(4'hF, 1'b1, 1'b1, 1'b0);
    checkTaps(0, "mid clear B R9");
    drive(4'hF, 1'b1, 1'b1, 1'b1);
    checkTaps(1, "restart R3");

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
    $finish;
  end

endmodule